// File: doc/BRIEF.md
# Dual-Source Divider Configuration Loader

This block holds the settings for a synthesizer's loop divider (9 bits), its output divider select (2 bits) and a 3-bit test-mode select. The settings can be written from either of two sources.

The first source is a parallel word with a load strobe. This is the path normally used at power-up. The second source is a three-wire serial port with a clock, a data line and a load line. It feeds a 14-bit shift register, which can later retune the settings.

All port inputs are treated as asynchronous. They pass through a synchronizer clocked by the block clock. Every latch behaviour is then emulated with clock-enabled flops. The synchronizer flops reset to each input's idle level: low for the serial lines, high for the parallel strobe and the parallel data.

Top module: `cfg_loader`

## Requirements
- R1: After reset `m_out`, `n_out`, `t_out` and `ser_tap` are all zero.
- R2: The shift register moves one place, toward its top stage, on each rising edge of `ser_clk`, taking in `ser_dat`; it does not move otherwise. `ser_tap` is the top stage, so after 14 shifts it shows the first bit sent.
- R3: A serial word is sent in this order: test bits first (bit 2 down to 0), then the output divider select (bit 1, then bit 0), then the loop divider (bit 8 down to bit 0). After a load, `t_out`, `n_out` and `m_out` hold these fields.
- R4: While `par_ld` is high and `ser_ld` is high, the three outputs follow the shift register contents, including shifts made during that time.
- R5: When `ser_ld` falls, the outputs keep the last value they followed. While `ser_ld` stays low, serial shifting does not change the outputs.
- R6: While `par_ld` is low, `m_out` follows `par_m` and `n_out` follows `par_n`.
- R7: When `par_ld` rises, `m_out` and `n_out` keep the values they held just before. Later changes on `par_m` and `par_n` have no effect while `par_ld` stays high.
- R8: The parallel path wins. A serial load (`ser_ld` pulsed) while `par_ld` is low leaves all three outputs at the parallel values, with `t_out` at zero.
- R9: While `par_ld` is low, `t_out` is 000. The parallel port cannot set the test bits, so `t_out` stays 000 after `par_ld` rises until the next serial load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; the shift happens on its rising edge |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load: the outputs are transparent while it is high and hold from its falling edge |
| par_ld | input | 1 | Parallel load: the outputs are transparent while it is low and capture on its rising edge; it has priority |
| par_m | input | 9 | Parallel loop divider value, bit 8 is the MSB |
| par_n | input | 2 | Parallel output divider select |
| m_out | output | 9 | Current loop divider setting |
| n_out | output | 2 | Current output divider select |
| t_out | output | 3 | Current test-mode select |
| ser_tap | output | 1 | Top stage of the shift register |

## Verification
The hardest case to reach from the ports is the conflict between the two paths. A full serial word must be shifted in and its load pulse applied while the parallel strobe is still low. The outputs must then show the parallel word with zero test bits, even after the strobe rises.

The stimulus sets up this conflict on purpose. A directed sequence creates it first. Random iterations then mix it with ordinary serial loads and parallel loads. This sequence also covers shifting while the serial load is held high, which shows whether the serial latch is transparent rather than edge-triggered.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 2;
  localparam int T_W  = 3;
  localparam int SR_W = T_W + N_W + M_W;

  // Field order matches the serial stream: test bits arrive first, so they sit on top.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] q_r;
      logic [W-1:0] q_d;
      if (i == 0) begin : g_first
        always_comb q_d = d;
      end else begin : g_next
        always_comb q_d = g_stg[i-1].q_r;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= q_d;
      end
    end
  endgenerate

  assign q = g_stg[STAGES-1].q_r;
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg
  import cfg_loader_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_s,
  input  logic            sdat_s,
  output logic [SR_W-1:0] sr_q,
  output logic            shift_ev
);
  logic            prev_q;
  logic [SR_W-1:0] sr_d;

  always_comb begin
    shift_ev = sclk_s & ~prev_q;
    sr_d     = {sr_q[SR_W-2:0], sdat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_ev) sr_q <= sr_d;
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_loader_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pl_s,
  input  logic           sl_s,
  input  logic [M_W-1:0] pm_s,
  input  logic [N_W-1:0] pn_s,
  input  cfg_t           sr_cfg,
  output cfg_t           cfg_q
);
  logic par_we;
  logic ser_we;
  logic we;
  cfg_t cfg_d;

  // Parallel strobe low: parallel path is transparent and blocks the serial path.
  always_comb begin
    par_we = ~pl_s;
    ser_we = pl_s & sl_s;
    we     = par_we | ser_we;
    if (par_we) begin
      cfg_d.t = '0;
      cfg_d.n = pn_s;
      cfg_d.m = pm_s;
    end else begin
      cfg_d = sr_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           par_ld,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           ser_tap
);
  localparam int SER_W = 3;
  localparam int PAR_W = 1 + M_W + N_W;

  logic [SER_W-1:0] ser_s;
  logic [PAR_W-1:0] par_s;
  logic             sclk_s, sdat_s, sl_s, pl_s;
  logic [M_W-1:0]   pm_s;
  logic [N_W-1:0]   pn_s;
  logic [SR_W-1:0]  sr_q;
  logic             shift_ev;
  cfg_t             cfg_q;

  // Serial lines idle low; parallel strobe and data idle high.
  cfg_sync #(.W(SER_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ser (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_dat, ser_ld}), .q(ser_s)
  );
  cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES), .RST_VAL({PAR_W{1'b1}})) u_sync_par (
    .clk(clk), .rst_n(rst_n), .d({par_ld, par_m, par_n}), .q(par_s)
  );

  assign {sclk_s, sdat_s, sl_s} = ser_s;
  assign {pl_s, pm_s, pn_s}     = par_s;

  cfg_shreg u_shreg (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdat_s(sdat_s),
    .sr_q(sr_q), .shift_ev(shift_ev)
  );

  cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .sl_s(sl_s),
    .pm_s(pm_s), .pn_s(pn_s), .sr_cfg(cfg_t'(sr_q)), .cfg_q(cfg_q)
  );

  assign m_out   = cfg_q.m;
  assign n_out   = cfg_q.n;
  assign t_out   = cfg_q.t;
  assign ser_tap = sr_q[SR_W-1];
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            pl_s,
  input logic            sl_s,
  input logic            shift_ev,
  input logic [SR_W-1:0] sr_q,
  input logic [M_W-1:0]  pm_s,
  input logic [N_W-1:0]  pn_s,
  input logic [SR_W-1:0] cfg_v,
  input logic            ser_tap
);
  a_r2_tap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> ser_tap == $past(sr_q[SR_W-2]));

  a_r2_no_spurious_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev |=> $stable(sr_q));

  a_r4_serial_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && sl_s) |=> cfg_v == $past(sr_q));

  a_r5_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && !sl_s) |=> $stable(cfg_v));

  a_r6_parallel_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> (cfg_v[M_W-1:0] == $past(pm_s)) && (cfg_v[M_W+N_W-1:M_W] == $past(pn_s)));

  a_r9_test_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> cfg_v[SR_W-1 -: T_W] == '0);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .sl_s(sl_s), .shift_ev(shift_ev),
  .sr_q(sr_q), .pm_s(pm_s), .pn_s(pn_s), .cfg_v(cfg_q), .ser_tap(ser_tap)
);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_dat, ser_ld, par_ld;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] t_out;
  logic       ser_tap;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [13:0] sr_m;
  logic [13:0] exp_w;

  always #5 clk = ~clk;

  cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
    .m_out(m_out), .n_out(n_out), .t_out(t_out), .ser_tap(ser_tap)
  );

  function automatic logic [13:0] pack_cfg(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_cfg(string req, logic [13:0] exp);
    logic [13:0] act;
    act = {t_out, n_out, m_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {t,n,m} = %h, expected %h", req, act, exp);
    end
  endtask

  task automatic chk_tap(string req, logic exp);
    checks++;
    if (ser_tap !== exp) begin
      errors++;
      $display("FAIL %s: ser_tap = %b, expected %b", req, ser_tap, exp);
    end
  endtask

  task automatic sbit(logic b);
    ser_dat = b;
    idle(4);
    ser_clk = 1'b1;
    idle(4);
    ser_clk = 1'b0;
    sr_m = {sr_m[12:0], b};
  endtask

  task automatic sword(logic [13:0] w);
    for (int i = 13; i >= 0; i--) sbit(w[i]);
    idle(8);
  endtask

  task automatic spulse();
    ser_ld = 1'b1;
    idle(8);
    ser_ld = 1'b0;
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] w;
    logic [8:0]  pm;
    logic [1:0]  pn;
    int          sel;
    sel = $urandom(32'h5eed);
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0;
    par_ld = 1'b1; par_m = '1; par_n = '1; sr_m = '0;
    idle(3);
    rst_n = 1'b1;
    idle(8);
    // R1: reset state
    chk_cfg("R1 reset", 14'h0);
    chk_tap("R1 reset tap", 1'b0);

    // Directed serial load: T=110 N=01 M=0x106
    w = pack_cfg(3'b110, 2'b01, 9'h106);
    sword(w);
    chk_cfg("R5 no change while ser_ld low", 14'h0);
    chk_tap("R2 tap shows first bit", w[13]);
    ser_ld = 1'b1;
    idle(8);
    chk_cfg("R3 field order", w);
    sbit(1'b1);
    idle(8);
    chk_cfg("R4 transparent while ser_ld high", sr_m);
    exp_w = sr_m;
    ser_ld = 1'b0;
    idle(8);
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
    idle(8);
    chk_cfg("R5 hold after falling ser_ld", exp_w);
    chk_tap("R2 tap after extra shifts", sr_m[13]);

    // Directed parallel path
    par_ld = 1'b0; par_m = 9'h0AA; par_n = 2'b10;
    idle(8);
    chk_cfg("R6/R9 parallel transparent", pack_cfg(3'b000, 2'b10, 9'h0AA));
    par_m = 9'h155; par_n = 2'b01;
    idle(8);
    chk_cfg("R6 follows new parallel data", pack_cfg(3'b000, 2'b01, 9'h155));
    par_ld = 1'b1;
    idle(8);
    par_m = 9'h1FF; par_n = 2'b11;
    idle(8);
    chk_cfg("R7/R9 capture on rising par_ld", pack_cfg(3'b000, 2'b01, 9'h155));

    // Directed priority conflict
    par_ld = 1'b0; par_m = 9'h033; par_n = 2'b00;
    idle(8);
    sword(pack_cfg(3'b111, 2'b11, 9'h1C3));
    spulse();
    chk_cfg("R8 parallel wins over serial load", pack_cfg(3'b000, 2'b00, 9'h033));
    par_ld = 1'b1;
    idle(8);
    chk_cfg("R9 test bits stay zero after par_ld rises", pack_cfg(3'b000, 2'b00, 9'h033));

    // Random mix
    exp_w = pack_cfg(3'b000, 2'b00, 9'h033);
    for (int it = 0; it < 30; it++) begin
      sel = $urandom % 3;
      w   = 14'($urandom);
      pm  = 9'($urandom);
      pn  = 2'($urandom);
      if (sel == 0) begin
        sword(w);
        chk_cfg("R5 random hold during shifting", exp_w);
        chk_tap("R2 random tap", w[13]);
        ser_ld = 1'b1;
        idle(8);
        chk_cfg("R3 random serial load", w);
        ser_ld = 1'b0;
        idle(8);
        exp_w = w;
      end else if (sel == 1) begin
        par_ld = 1'b0; par_m = pm; par_n = pn;
        idle(8);
        chk_cfg("R6 random parallel follow", pack_cfg(3'b000, pn, pm));
        par_ld = 1'b1;
        idle(8);
        par_m = 9'($urandom); par_n = 2'($urandom);
        idle(8);
        exp_w = pack_cfg(3'b000, pn, pm);
        chk_cfg("R7 random parallel capture", exp_w);
      end else begin
        par_ld = 1'b0; par_m = pm; par_n = pn;
        idle(8);
        sword(w);
        spulse();
        exp_w = pack_cfg(3'b000, pn, pm);
        chk_cfg("R8 random priority", exp_w);
        par_ld = 1'b1;
        idle(8);
        chk_cfg("R9 random test bits zero", exp_w);
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule